// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the branch divergence stack of one warp in a SIMT core. Each stack entry carries a program counter, a mask of the lanes that run at that counter, and the counter at which those lanes are to reconverge. Fetch reads the top entry to learn which PC to issue and for which lanes.

After a warp instruction completes, the core presents every lane's next PC, a mask of lanes that have finished, and the immediate post-dominator of the instruction. The block then scans the top entry's lanes, one group of equal next PCs per cycle. Groups that have reached the reconvergence point vanish. The old top becomes a reconvergence entry when the lanes split. The surviving groups are written back on top. An update that leaves nothing pops the entry. A PC value of zero is reserved to mean "no reconvergence point" and is never used as a lane's next PC.

The controller has two states. IDLE exposes the top entry and accepts a load or an update. SCAN forms one lane group per cycle. The transitions are: IDLE to SCAN on an accepted update, SCAN to SCAN while lanes remain unmatched, and SCAN to IDLE on the commit cycle in which no lane remains. A load keeps the block in IDLE.

Top module: `dvs_reconv_stack`

## Requirements
- R1: After reset the stack is empty: depth 0, top_valid 0, busy 0.
- R2: In IDLE, a load (init_valid) replaces the stack with one entry {init_pc, init_mask, reconvergence 0, stamp 0} and depth 1; it takes priority over an update in the same cycle. init_mask must be nonzero.
- R3: When all live lanes share one next PC and no group is dropped, the top entry's PC becomes that PC, its reconvergence PC is kept, and depth does not change.
- R4: Lanes are grouped by scanning from the highest lane (bit LANES-1 of every mask; lane i's PC is upd_next_pc[i*PC_W +: PC_W]) down to lane 0. The highest unmatched lane leads each group. Groups are pushed in the order they are formed, so the group led by the lowest lane ends on top. Pushed groups carry the new reconvergence PC (upd_ipdom).
- R5: A group whose PC equals the reconvergence PC of the entry being updated is dropped. If every group is dropped, the entry is popped.
- R6: On a split, the old top's PC is replaced by upd_ipdom and the groups go above it. This happens only when upd_ipdom differs from the old top's reconvergence PC. Otherwise the groups are written starting at the old top's slot, and depth grows by the group count minus one.
- R7: Once a split has occurred, a group whose PC equals upd_ipdom is dropped.
- R8: A lane set in upd_done leaves the mask and joins no group. An update in which every live lane is done pops the entry.
- R9: A free-running cycle counter starts at 0 on reset release and adds 1 per clock. A rewritten reconvergence entry records the counter value of the scan cycle in which the split is found. Entries pushed above the old top record 0.
- R10: An update spends one SCAN cycle per group formed plus one commit cycle. During SCAN, busy is 1, top_valid is 0, and load and update requests are ignored.
- R11: An update presented while the stack is empty is ignored: no SCAN cycle occurs and depth stays 0.
- R12: Depth never exceeds 2*LANES, and a valid top entry never has an empty mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_valid | input | 1 | Load a single entry (warp launch) |
| init_pc | input | PC_W | PC of the loaded entry |
| init_mask | input | LANES | Lane mask of the loaded entry |
| upd_valid | input | 1 | Start an update of the top entry |
| upd_next_pc | input | LANES*PC_W | Next PC per lane, lane i at bits i*PC_W |
| upd_done | input | LANES | Lanes that have finished |
| upd_ipdom | input | PC_W | Post-dominator of the instruction just executed |
| busy | output | 1 | Update in progress |
| top_valid | output | 1 | Top entry visible to fetch |
| top_pc | output | PC_W | PC of the top entry |
| top_mask | output | LANES | Lane mask of the top entry |
| top_rpc | output | PC_W | Reconvergence PC of the top entry |
| top_stamp | output | CYC_W | Split cycle stamp of the top entry |
| depth | output | IW | Number of stack entries |

## Verification
The assertions take for granted that no load carries an empty mask, that no lane's next PC is zero, and that updates stay within the nesting the stack can hold. The directed stimulus loads only nonzero masks and uses small nonzero PCs. It nests at most two levels deep, well under 2*LANES entries. Requests made while busy are issued on purpose, to show they are ignored. Every update waits for busy to fall before the next one is issued.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } dvs_state_e;
endpackage

// File: rtl/dvs_lane_group.sv
// Forms one group of lanes sharing a next PC, scanning from the top lane down.
module dvs_lane_group #(
    parameter int LANES = 4,
    parameter int PC_W  = 8
) (
    input  logic [LANES-1:0]      live_mask,
    input  logic [LANES-1:0]      done_mask,
    input  logic [LANES*PC_W-1:0] lane_pc,
    output logic [PC_W-1:0]       grp_pc,
    output logic [LANES-1:0]      grp_mask,
    output logic [LANES-1:0]      rest_mask
);
    always_comb begin
        logic found;
        found     = 1'b0;
        grp_pc    = '0;
        grp_mask  = '0;
        rest_mask = live_mask;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (live_mask[i]) begin
                if (done_mask[i]) begin
                    rest_mask[i] = 1'b0;
                end else if (!found) begin
                    found        = 1'b1;
                    grp_pc       = lane_pc[i*PC_W +: PC_W];
                    grp_mask[i]  = 1'b1;
                    rest_mask[i] = 1'b0;
                end else if (lane_pc[i*PC_W +: PC_W] == grp_pc) begin
                    grp_mask[i]  = 1'b1;
                    rest_mask[i] = 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/dvs_entry_store.sv
// Stack storage: port A rewrites PC and stamp, port B writes a whole entry.
module dvs_entry_store #(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int CYC_W = 16,
    parameter int DEPTH = 8,
    parameter int IW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             a_en,
    input  logic [IW-1:0]    a_idx,
    input  logic [PC_W-1:0]  a_pc,
    input  logic [CYC_W-1:0] a_stamp,
    input  logic             b_en,
    input  logic [IW-1:0]    b_idx,
    input  logic [PC_W-1:0]  b_pc,
    input  logic [LANES-1:0] b_mask,
    input  logic [PC_W-1:0]  b_rpc,
    input  logic             b_stamp_clr,
    input  logic [IW-1:0]    rd_idx,
    output logic [PC_W-1:0]  rd_pc,
    output logic [LANES-1:0] rd_mask,
    output logic [PC_W-1:0]  rd_rpc,
    output logic [CYC_W-1:0] rd_stamp
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PC_W-1:0]  pc_r    [DEPTH];
    logic [LANES-1:0] mask_r  [DEPTH];
    logic [PC_W-1:0]  rpc_r   [DEPTH];
    logic [CYC_W-1:0] stamp_r [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < DEPTH; e++) begin
                pc_r[e]    <= '0;
                mask_r[e]  <= '0;
                rpc_r[e]   <= '0;
                stamp_r[e] <= '0;
            end
        end else begin
            for (int e = 0; e < DEPTH; e++) begin
                if (a_en && a_idx == IW'(e)) begin
                    pc_r[e]    <= a_pc;
                    stamp_r[e] <= a_stamp;
                end
                if (b_en && b_idx == IW'(e)) begin
                    pc_r[e]   <= b_pc;
                    mask_r[e] <= b_mask;
                    rpc_r[e]  <= b_rpc;
                    if (b_stamp_clr) stamp_r[e] <= '0;
                end
            end
        end
    end

    logic in_range;
    assign in_range = (rd_idx < IW'(DEPTH));

    always_comb begin
        rd_pc    = '0;
        rd_mask  = '0;
        rd_rpc   = '0;
        rd_stamp = '0;
        if (in_range) begin
            rd_pc    = pc_r[rd_idx[AW-1:0]];
            rd_mask  = mask_r[rd_idx[AW-1:0]];
            rd_rpc   = rpc_r[rd_idx[AW-1:0]];
            rd_stamp = stamp_r[rd_idx[AW-1:0]];
        end
    end
endmodule

// File: rtl/dvs_reconv_stack.sv
module dvs_reconv_stack #(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int CYC_W = 16,
    localparam int DEPTH = 2 * LANES,
    localparam int IW    = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  init_valid,
    input  logic [PC_W-1:0]       init_pc,
    input  logic [LANES-1:0]      init_mask,
    input  logic                  upd_valid,
    input  logic [LANES*PC_W-1:0] upd_next_pc,
    input  logic [LANES-1:0]      upd_done,
    input  logic [PC_W-1:0]       upd_ipdom,
    output logic                  busy,
    output logic                  top_valid,
    output logic [PC_W-1:0]       top_pc,
    output logic [LANES-1:0]      top_mask,
    output logic [PC_W-1:0]       top_rpc,
    output logic [CYC_W-1:0]      top_stamp,
    output logic [IW-1:0]         depth
);
    import dvs_pkg::*;

    dvs_state_e state_q, state_n;

    logic [LANES-1:0]      m_q;
    logic [IW-1:0]         wi_q, orig_q, depth_q;
    logic [PC_W-1:0]       base_rpc_q, nrpc_q, ipdom_q;
    logic                  div_q;
    logic [LANES*PC_W-1:0] npc_q;
    logic [LANES-1:0]      done_q;
    logic [CYC_W-1:0]      cyc_q;

    // store ports
    logic [PC_W-1:0]  rd_pc, rd_rpc;
    logic [LANES-1:0] rd_mask;
    logic [CYC_W-1:0] rd_stamp;
    logic             a_en, b_en, b_stamp_clr;
    logic [IW-1:0]    a_idx, b_idx, rd_idx;
    logic [PC_W-1:0]  b_pc, b_rpc;
    logic [LANES-1:0] b_mask;

    // group picker
    logic [PC_W-1:0]  grp_pc;
    logic [LANES-1:0] grp_mask, rest_mask;

    dvs_lane_group #(.LANES(LANES), .PC_W(PC_W)) u_group (
        .live_mask (m_q),
        .done_mask (done_q),
        .lane_pc   (npc_q),
        .grp_pc    (grp_pc),
        .grp_mask  (grp_mask),
        .rest_mask (rest_mask)
    );

    dvs_entry_store #(
        .LANES(LANES), .PC_W(PC_W), .CYC_W(CYC_W), .DEPTH(DEPTH), .IW(IW)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .a_en        (a_en),
        .a_idx       (a_idx),
        .a_pc        (ipdom_q),
        .a_stamp     (cyc_q),
        .b_en        (b_en),
        .b_idx       (b_idx),
        .b_pc        (b_pc),
        .b_mask      (b_mask),
        .b_rpc       (b_rpc),
        .b_stamp_clr (b_stamp_clr),
        .rd_idx      (rd_idx),
        .rd_pc       (rd_pc),
        .rd_mask     (rd_mask),
        .rd_rpc      (rd_rpc),
        .rd_stamp    (rd_stamp)
    );

    // request decode in IDLE
    logic in_idle, in_scan, do_init, do_upd;
    assign in_idle = (state_q == ST_IDLE);
    assign in_scan = (state_q == ST_SCAN);
    assign do_init = in_idle && init_valid;
    assign do_upd  = in_idle && !init_valid && upd_valid && (depth_q != '0);
    assign rd_idx  = depth_q - IW'(1);

    // per-group decisions during SCAN
    logic            scan_end, keep, div_now, div_eff, push_rec, write_grp;
    logic [PC_W-1:0] nrpc_eff;
    logic [IW-1:0]   widx;

    always_comb begin
        scan_end  = in_scan && (m_q == '0);
        keep      = in_scan && !scan_end && (grp_mask != '0) && (grp_pc != base_rpc_q);
        div_now   = keep && (rest_mask != '0) && !div_q;
        div_eff   = div_q || div_now;
        nrpc_eff  = div_now ? ipdom_q : nrpc_q;
        push_rec  = div_now && (ipdom_q != base_rpc_q);
        widx      = wi_q + IW'(push_rec);
        write_grp = keep && !(div_eff && (grp_pc == nrpc_eff));
    end

    always_comb begin
        a_en        = push_rec;
        a_idx       = wi_q;
        b_en        = do_init || write_grp;
        b_idx       = do_init ? '0 : widx;
        b_pc        = do_init ? init_pc : grp_pc;
        b_mask      = do_init ? init_mask : grp_mask;
        b_rpc       = do_init ? '0 : (div_eff ? nrpc_eff : base_rpc_q);
        b_stamp_clr = do_init || (widx != orig_q);
    end

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: if (do_upd)   state_n = ST_SCAN;
            ST_SCAN: if (scan_end) state_n = ST_IDLE;
            default:               state_n = ST_IDLE;
        endcase
    end

    // state register and scan context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            m_q        <= '0;
            wi_q       <= '0;
            orig_q     <= '0;
            depth_q    <= '0;
            base_rpc_q <= '0;
            nrpc_q     <= '0;
            ipdom_q    <= '0;
            div_q      <= 1'b0;
            npc_q      <= '0;
            done_q     <= '0;
            cyc_q      <= '0;
        end else begin
            state_q <= state_n;
            cyc_q   <= cyc_q + CYC_W'(1);
            if (do_init) begin
                depth_q <= IW'(1);
            end else if (do_upd) begin
                m_q        <= rd_mask;
                wi_q       <= rd_idx;
                orig_q     <= rd_idx;
                base_rpc_q <= rd_rpc;
                nrpc_q     <= '0;
                div_q      <= 1'b0;
                ipdom_q    <= upd_ipdom;
                npc_q      <= upd_next_pc;
                done_q     <= upd_done;
            end else if (scan_end) begin
                depth_q <= wi_q;
            end else if (in_scan) begin
                m_q    <= rest_mask;
                div_q  <= div_eff;
                nrpc_q <= nrpc_eff;
                wi_q   <= widx + IW'(write_grp);
            end
        end
    end

    // outputs
    always_comb begin
        busy      = in_scan;
        top_valid = in_idle && (depth_q != '0);
        top_pc    = top_valid ? rd_pc    : '0;
        top_mask  = top_valid ? rd_mask  : '0;
        top_rpc   = top_valid ? rd_rpc   : '0;
        top_stamp = top_valid ? rd_stamp : '0;
        depth     = depth_q;
    end
endmodule

// File: rtl/dvs_reconv_stack_chk.sv
module dvs_reconv_stack_chk #(
    parameter int LANES = 4,
    parameter int PC_W  = 8,
    parameter int CYC_W = 16,
    parameter int IW    = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             init_valid,
    input logic [PC_W-1:0]  init_pc,
    input logic [LANES-1:0] init_mask,
    input logic             upd_valid,
    input logic             busy,
    input logic             top_valid,
    input logic [PC_W-1:0]  top_pc,
    input logic [LANES-1:0] top_mask,
    input logic [IW-1:0]    depth
);
    // R2
    load_one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (init_valid && !busy) |=> (depth == IW'(1) && top_pc == $past(init_pc)
                                   && top_mask == $past(init_mask)));

    // R10
    scan_hides_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !top_valid);

    // R10
    update_starts_scan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !init_valid && upd_valid && depth != '0) |=> busy);

    // R11
    empty_update_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !init_valid && upd_valid && depth == '0) |=> (!busy && depth == '0));

    // R12
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth <= IW'(2 * LANES));

    // R12
    live_top_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> (top_mask != '0));
endmodule

bind dvs_reconv_stack dvs_reconv_stack_chk #(
    .LANES(LANES), .PC_W(PC_W), .CYC_W(CYC_W), .IW(IW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .init_valid (init_valid),
    .init_pc    (init_pc),
    .init_mask  (init_mask),
    .upd_valid  (upd_valid),
    .busy       (busy),
    .top_valid  (top_valid),
    .top_pc     (top_pc),
    .top_mask   (top_mask),
    .depth      (depth)
);

// File: tb/test_dvs_reconv_stack.sv
module test_dvs_reconv_stack;
    localparam int LANES = 4;
    localparam int PC_W  = 8;
    localparam int CYC_W = 16;
    localparam int IW    = $clog2(2 * LANES + 1);

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  init_valid = 1'b0;
    logic [PC_W-1:0]       init_pc = '0;
    logic [LANES-1:0]      init_mask = '0;
    logic                  upd_valid = 1'b0;
    logic [LANES*PC_W-1:0] upd_next_pc = '0;
    logic [LANES-1:0]      upd_done = '0;
    logic [PC_W-1:0]       upd_ipdom = '0;
    logic                  busy, top_valid;
    logic [PC_W-1:0]       top_pc, top_rpc;
    logic [LANES-1:0]      top_mask;
    logic [CYC_W-1:0]      top_stamp;
    logic [IW-1:0]         depth;

    int checks = 0;
    int failures = 0;
    int tbc = 0;
    int wd = 0;

    always #4 clk = ~clk;

    dvs_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .CYC_W(CYC_W)) i_dvs_reconv_stack (
        .clk(clk), .rst_n(rst_n), .init_valid(init_valid), .init_pc(init_pc),
        .init_mask(init_mask), .upd_valid(upd_valid), .upd_next_pc(upd_next_pc),
        .upd_done(upd_done), .upd_ipdom(upd_ipdom), .busy(busy), .top_valid(top_valid),
        .top_pc(top_pc), .top_mask(top_mask), .top_rpc(top_rpc), .top_stamp(top_stamp),
        .depth(depth)
    );

    // cycle counter per R9: 0 at reset release, +1 per clock
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbc <= 0;
        else        tbc <= tbc + 1;
    end

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd == 20000) begin
            failures++;
            $display("FAIL watchdog: run hung, actual=%0d expected<20000 cycles", wd);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_top(input string tag, input logic [7:0] pc, input logic [3:0] mask,
                           input logic [7:0] rpc, input int dep);
        chk({tag, " valid"}, 32'(top_valid), 32'(dep != 0));
        chk({tag, " pc"},    32'(top_pc),    32'(pc));
        chk({tag, " mask"},  32'(top_mask),  32'(mask));
        chk({tag, " rpc"},   32'(top_rpc),   32'(rpc));
        chk({tag, " depth"}, 32'(depth),     32'(dep));
    endtask

    task automatic do_init(input logic [7:0] pc, input logic [3:0] mask);
        @(negedge clk);
        init_valid = 1'b1; init_pc = pc; init_mask = mask;
        @(negedge clk);
        init_valid = 1'b0;
    endtask

    task automatic do_upd(input logic [7:0] p3, input logic [7:0] p2, input logic [7:0] p1,
                          input logic [7:0] p0, input logic [3:0] dn, input logic [7:0] ip,
                          output int nbusy, output int issue);
        @(negedge clk);
        upd_valid = 1'b1; upd_next_pc = {p3, p2, p1, p0}; upd_done = dn; upd_ipdom = ip;
        issue = tbc;
        @(negedge clk);
        upd_valid = 1'b0;
        nbusy = 0;
        while (busy) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 depth", 32'(depth), 0);
        chk("R1 top_valid", 32'(top_valid), 0);
        chk("R1 busy", 32'(busy), 0);
    endtask

    task automatic t_uniform;
        int nb, is;
        do_init(8'h10, 4'hF);
        chk_top("R2 load", 8'h10, 4'hF, 8'h00, 1);
        chk("R2 stamp", 32'(top_stamp), 0);
        do_upd(8'h14, 8'h14, 8'h14, 8'h14, 4'h0, 8'h00, nb, is);
        chk_top("R3 uniform", 8'h14, 4'hF, 8'h00, 1);
        chk("R10 one group cycles", 32'(nb), 2);
    endtask

    task automatic t_diverge;
        int nb, is, c;
        do_init(8'h10, 4'hF);
        do_upd(8'h20, 8'h20, 8'h30, 8'h30, 4'h0, 8'h40, nb, c);
        chk("R10 two group cycles", 32'(nb), 3);
        chk_top("R4 split top", 8'h30, 4'h3, 8'h40, 3);
        chk("R9 pushed stamp", 32'(top_stamp), 0);
        do_upd(8'h77, 8'h77, 8'h38, 8'h38, 4'h0, 8'h99, nb, is);
        chk_top("R3 inherit rpc", 8'h38, 4'h3, 8'h40, 3);
        do_upd(8'h77, 8'h77, 8'h40, 8'h40, 4'h0, 8'h99, nb, is);
        chk_top("R5 reconverge pop", 8'h20, 4'hC, 8'h40, 2);
        do_upd(8'h40, 8'h40, 8'h77, 8'h77, 4'h0, 8'h99, nb, is);
        chk_top("R5 back to base", 8'h40, 4'hF, 8'h00, 1);
        chk("R9 split stamp", 32'(top_stamp), 32'(c + 1));
    endtask

    task automatic t_same_rpc;
        int nb, is;
        do_init(8'h10, 4'hF);
        do_upd(8'h20, 8'h20, 8'h30, 8'h30, 4'h0, 8'h40, nb, is);
        do_upd(8'h77, 8'h77, 8'h34, 8'h38, 4'h0, 8'h40, nb, is);
        chk_top("R6 no rewrite", 8'h38, 4'h1, 8'h40, 4);
        chk("R12 depth bound", 32'(depth <= IW'(2 * LANES)), 1);
        do_upd(8'h77, 8'h77, 8'h77, 8'h55, 4'h1, 8'h40, nb, is);
        chk_top("R8 done pop", 8'h34, 4'h2, 8'h40, 3);
    endtask

    task automatic t_drop_new;
        int nb, is;
        do_init(8'h10, 4'hF);
        do_upd(8'h20, 8'h70, 8'h70, 8'h70, 4'h0, 8'h70, nb, is);
        chk_top("R7 drop new rpc group", 8'h20, 4'h8, 8'h70, 2);
    endtask

    task automatic t_done_lane;
        int nb, is;
        do_init(8'h10, 4'hF);
        do_upd(8'h55, 8'h20, 8'h30, 8'h30, 4'h8, 8'h40, nb, is);
        chk_top("R8 done lane split", 8'h30, 4'h3, 8'h40, 3);
        do_upd(8'h77, 8'h77, 8'h40, 8'h40, 4'h0, 8'h99, nb, is);
        chk_top("R8 done lane excluded", 8'h20, 4'h4, 8'h40, 2);
    endtask

    task automatic t_order;
        int nb, is;
        do_init(8'h10, 4'hF);
        do_upd(8'h20, 8'h30, 8'h20, 8'h30, 4'h0, 8'h40, nb, is);
        chk_top("R4 interleaved top", 8'h30, 4'h5, 8'h40, 3);
        do_upd(8'h77, 8'h40, 8'h77, 8'h40, 4'h0, 8'h99, nb, is);
        chk_top("R4 interleaved below", 8'h20, 4'hA, 8'h40, 2);
    endtask

    task automatic t_empty;
        int nb, is;
        do_init(8'h10, 4'hF);
        do_upd(8'h11, 8'h11, 8'h11, 8'h11, 4'hF, 8'h40, nb, is);
        chk_top("R8 all done pops", 8'h00, 4'h0, 8'h00, 0);
        do_upd(8'h20, 8'h20, 8'h30, 8'h30, 4'h0, 8'h40, nb, is);
        chk("R11 no scan", 32'(nb), 0);
        chk_top("R11 still empty", 8'h00, 4'h0, 8'h00, 0);
    endtask

    task automatic t_busy_ignore;
        do_init(8'h10, 4'hF);
        @(negedge clk);
        upd_valid = 1'b1; upd_next_pc = {4{8'h14}}; upd_done = 4'h0; upd_ipdom = 8'h00;
        @(negedge clk);
        chk("R10 busy", 32'(busy), 1);
        chk("R10 top hidden", 32'(top_valid), 0);
        upd_next_pc = {8'h20, 8'h20, 8'h30, 8'h30}; upd_ipdom = 8'h40;
        init_valid = 1'b1; init_pc = 8'h66; init_mask = 4'h1;
        @(negedge clk);
        upd_valid = 1'b0; init_valid = 1'b0;
        while (busy) @(negedge clk);
        chk_top("R10 requests ignored", 8'h14, 4'hF, 8'h00, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_uniform();
        t_diverge();
        t_same_rpc();
        t_drop_new();
        t_done_lane();
        t_order();
        t_empty();
        t_busy_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule